// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Controller

This block gathers 32 external interrupt lines and presents two interrupt requests to a processor: a normal request and a critical request. Each line passes through a two-flop synchroniser and then a per-line detector. Software picks edge or level sensing for each line and the active direction of that line. When a line's condition occurs, the line's pending bit is set, even if the line is not enabled. An enable word gates the pending bits into a masked view. A routing word sends each enabled pending line to one of the two requests.

Software uses a word-addressed register port with separate read and write strobes. It reads the pending and masked words, writes the configuration words, and clears pending bits by writing ones. A level-sensed line that is still at its active level cannot be cleared: its pending bit comes back on the next cycle. Line n sits at bit position 31−n in every word, so line 0 is the most significant bit.

Top module: `irq_ctrl32`

## Requirements
- R1: Line n (0..31) maps to bit 31−n of every register word, so line 0 is bit 31 and line 31 is bit 0.
- R2: Word offsets are: 0x0 pending, 0x2 enable, 0x3 routing, 0x4 polarity, 0x5 trigger and 0x6 masked. A read returns the selected word on `rd_data` on the clock edge that samples `rd_en`. Every other offset, including 0x1, 0x7 and 0x8, reads zero and ignores writes. Writes to offset 0x6 are ignored.
- R3: Trigger bit 1 selects edge sensing and 0 selects level sensing. Polarity bit 1 selects a rising edge or an active-high level. Polarity bit 0 selects a falling edge or an active-low level.
- R4: The pending word is write-one-to-clear. A 1 clears that bit and a 0 leaves it unchanged.
- R5: The pending bit of a level-sensed line that is still at its active level stays set after a clear, whether the line is enabled or not.
- R6: A pending bit is set by its line's condition regardless of the enable bit.
- R7: The masked word reads pending AND enable. Both requests stay low while no enabled line is pending.
- R8: Routing bit 0 sends the line to `irq_normal`. Routing bit 1 sends it to `irq_critical`. Each request is the registered OR of its enabled pending lines.
- R9: When a clear write and a new capture hit the same bit on the same clock edge, the bit ends up set.
- R10: After reset, all registers read zero and both requests are low, provided the lines are held high.
- R11: An input change driven just before a clock edge raises the routed request on the fourth rising edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Raw interrupt lines, index n is line n |
| reg_addr | input | 4 | Word offset for register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq_normal | output | 1 | Normal interrupt request |
| irq_critical | output | 1 | Critical interrupt request |

## Verification
The hardest case to reach from the ports is the race between a clear write and a new capture on the same edge. An edge event is visible to the pending register during only one clock cycle, three synchroniser and detector stages after the input moves. The bench drives a rising edge on a line, counts two rising edges, and then holds a clear write to that line's bit across the third edge, so that the write and the capture land together. It then confirms through a read that the bit survived.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 4;

  localparam logic [AW-1:0] OFS_PEND  = 4'h0;
  localparam logic [AW-1:0] OFS_EN    = 4'h2;
  localparam logic [AW-1:0] OFS_ROUTE = 4'h3;
  localparam logic [AW-1:0] OFS_POL   = 4'h4;
  localparam logic [AW-1:0] OFS_TRIG  = 4'h5;
  localparam logic [AW-1:0] OFS_MASK  = 4'h6;

  typedef logic [NSRC-1:0] word_t;

  // Bit position holding line n: MSB-first numbering.
  function automatic int unsigned line_bit(int unsigned n);
    return NSRC - 1 - n;
  endfunction

  // Detect the configured condition on one synchronised line.
  function automatic logic sense_hit(logic cur, logic prev, logic edge_mode, logic act_high);
    if (edge_mode)
      return act_high ? (cur & ~prev) : (~cur & prev);
    else
      return act_high ? cur : ~cur;
  endfunction
endpackage

// File: rtl/irqc_sense.sv
module irqc_sense
  import irqc_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,   // line order
  input  logic [N-1:0] trig_q,  // bit order
  input  logic [N-1:0] pol_q,   // bit order
  output logic [N-1:0] hit      // bit order
);
  for (genvar n = 0; n < N; n++) begin : g_line
    localparam int unsigned B = N - 1 - n;
    logic s1, s2, s3;

    // Flops reset high so idle-high lines raise no event at reset release.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= lines[n];
        s2 <= s1;
        s3 <= s2;
      end
    end

    assign hit[B] = sense_hit(s2, s3, trig_q[B], pol_q[B]);

    // R3: with fixed configuration an edge produces a single-cycle event
    p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q[B] && hit[B] && $stable(trig_q[B]) && $stable(pol_q[B]))
        |=> (!hit[B] || !$stable(pol_q[B]) || !$stable(trig_q[B])));
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned N = NSRC,
  parameter int unsigned A = AW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [A-1:0] addr,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  input  logic         rd,
  input  logic [N-1:0] hit,
  output logic [N-1:0] rdata,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] en_q,
  output logic [N-1:0] route_q,
  output logic [N-1:0] trig_q,
  output logic [N-1:0] pol_q,
  output logic [N-1:0] masked
);
  logic [N-1:0] clr;   // bits a write asks to clear this cycle
  logic         cfg_wr;

  assign clr    = (wr && addr == OFS_PEND) ? wdata : '0;
  assign cfg_wr = wr && (addr == OFS_EN || addr == OFS_ROUTE ||
                         addr == OFS_POL || addr == OFS_TRIG);
  assign masked = pend_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
      trig_q  <= '0;
      pol_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | hit;   // capture wins over clear
      if (wr) begin
        case (addr)
          OFS_EN:    en_q    <= wdata;
          OFS_ROUTE: route_q <= wdata;
          OFS_POL:   pol_q   <= wdata;
          OFS_TRIG:  trig_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        OFS_PEND:  rdata <= pend_q;
        OFS_EN:    rdata <= en_q;
        OFS_ROUTE: rdata <= route_q;
        OFS_POL:   rdata <= pol_q;
        OFS_TRIG:  rdata <= trig_q;
        OFS_MASK:  rdata <= masked;
        default:   rdata <= '0;
      endcase
    end
  end

  // R4: a cleared bit with no concurrent event reads zero next cycle
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((pend_q & $past(clr & ~hit)) == '0));

  // R4: no event and no clear leaves pending unchanged
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0 && hit == '0) |=> $stable(pend_q));

  // R9: every event sets its bit, even against a clear
  p_capture_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));

  // R2: configuration only moves on a configuration write
  p_cfg_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(en_q) && $stable(route_q) && $stable(trig_q) && $stable(pol_q)));
endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_lines,
  input  logic [AW-1:0]   reg_addr,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_data,
  input  logic            rd_en,
  output logic [NSRC-1:0] rd_data,
  output logic            irq_normal,
  output logic            irq_critical
);
  word_t hit, pend_q, en_q, route_q, trig_q, pol_q, masked;
  logic  want_norm, want_crit;

  irqc_sense #(.N(NSRC)) u_sense (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines),
    .trig_q(trig_q), .pol_q(pol_q), .hit(hit)
  );

  irqc_regs #(.N(NSRC), .A(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(wr_en), .wdata(wr_data),
    .rd(rd_en), .hit(hit), .rdata(rd_data), .pend_q(pend_q), .en_q(en_q),
    .route_q(route_q), .trig_q(trig_q), .pol_q(pol_q), .masked(masked)
  );

  assign want_norm = |(masked & ~route_q);
  assign want_crit = |(masked & route_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_normal   <= 1'b0;
      irq_critical <= 1'b0;
    end else begin
      irq_normal   <= want_norm;
      irq_critical <= want_crit;
    end
  end

  // R7: nothing enabled means both requests low on the next cycle
  p_masked_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> (!irq_normal && !irq_critical));

  // R8: with no line routed critical the critical request stays low
  p_route_crit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |=> !irq_critical);

  // R8: with every line routed critical the normal request stays low
  p_route_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '1) |=> !irq_normal);

  // R6: a pending bit never drops without a clear write to it
  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_addr == OFS_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: tb/irq_ctrl32_bench.sv
`timescale 1ns/1ps
module irq_ctrl32_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '1;
  logic [3:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq_normal, irq_critical;

  int n_run = 0;
  int n_fail = 0;

  irq_ctrl32 u_irq_ctrl32 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq_normal(irq_normal), .irq_critical(irq_critical)
  );

  always #4 clk = ~clk;

  // Line n lives at bit 31-n (R1), written as a right shift of the top bit.
  function automatic logic [31:0] lb(int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cleanup();
    irq_lines = '1;
    settle();
    wr(4'h2, 32'h0);
    wr(4'h3, 32'h0);
    wr(4'h5, 32'h0);
    wr(4'h4, 32'h0);
    settle();
    wr(4'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), v);
      check($sformatf("R10 offset %0d", a), v, 32'h0);
    end
    check("R10 requests", {30'h0, irq_normal, irq_critical}, 32'h0);
  endtask

  task automatic t_rising_latency();
    logic [31:0] v;
    wr(4'h5, lb(3));
    wr(4'h4, lb(3));
    irq_lines[3] = 1'b0;
    settle();
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v);
    check("R3 falling ignored in rising mode", v, 32'h0);
    wr(4'h2, lb(3));
    irq_lines[3] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 not yet after 3 edges", {31'h0, irq_normal}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R11 raised on 4th edge", {31'h0, irq_normal}, 32'h1);
    rd(4'h0, v);
    check("R1 line 3 at bit 28", v, 32'h1000_0000);
    wr(4'h0, 32'h0);
    rd(4'h0, v);
    check("R4 write zero keeps bit", v, lb(3));
    wr(4'h0, lb(3));
    rd(4'h0, v);
    check("R4 write one clears edge bit", v, 32'h0);
    @(negedge clk);
    check("R7 request drops after clear", {31'h0, irq_normal}, 32'h0);
    cleanup();
  endtask

  task automatic t_falling();
    logic [31:0] v;
    wr(4'h5, lb(10));
    settle();
    wr(4'h0, 32'hFFFF_FFFF);
    irq_lines[10] = 1'b0;
    settle();
    rd(4'h0, v);
    check("R3 falling edge captured", v, lb(10));
    wr(4'h0, lb(10));
    irq_lines[10] = 1'b1;
    settle();
    rd(4'h0, v);
    check("R3 rising ignored in falling mode", v, 32'h0);
    cleanup();
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    irq_lines[20] = 1'b0;
    wr(4'h4, lb(20));
    settle();
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v);
    check("R3 low input inactive in high mode", v, 32'h0);
    irq_lines[20] = 1'b1;
    settle();
    rd(4'h0, v);
    check("R6 captured while disabled", v, lb(20));
    rd(4'h6, v);
    check("R7 masked zero while disabled", v, 32'h0);
    wr(4'h0, lb(20));
    rd(4'h0, v);
    check("R5 level bit survives clear (disabled)", v, lb(20));
    wr(4'h2, lb(20));
    wr(4'h0, lb(20));
    rd(4'h6, v);
    check("R5 level bit survives clear (enabled)", v, lb(20));
    check("R8 normal request", {30'h0, irq_normal, irq_critical}, 32'h2);
    irq_lines[20] = 1'b0;
    settle();
    wr(4'h0, lb(20));
    rd(4'h0, v);
    check("R5 clears once inactive", v, 32'h0);
    cleanup();
  endtask

  task automatic t_level_low_crit();
    logic [31:0] v;
    wr(4'h3, lb(31));
    wr(4'h2, lb(31));
    irq_lines[31] = 1'b0;
    settle();
    rd(4'h6, v);
    check("R1 line 31 at bit 0", v, 32'h0000_0001);
    check("R8 critical request", {30'h0, irq_normal, irq_critical}, 32'h1);
    cleanup();
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(4'h5, lb(5));
    wr(4'h4, lb(5));
    irq_lines[5] = 1'b0;
    settle();
    wr(4'h0, 32'hFFFF_FFFF);
    irq_lines[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    reg_addr = 4'h0; wr_data = lb(5); wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    rd(4'h0, v);
    check("R9 capture beats same-edge clear", v, lb(5));
    wr(4'h0, lb(5));
    rd(4'h0, v);
    check("R4 later clear succeeds", v, 32'h0);
    cleanup();
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(4'h2, 32'h00F0_0000);
    wr(4'h6, 32'hFFFF_FFFF);
    wr(4'h7, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h6, v);
    check("R2 masked read-only", v, 32'h0);
    rd(4'h7, v);
    check("R2 offset 7 reads zero", v, 32'h0);
    rd(4'h8, v);
    check("R2 offset 8 reads zero", v, 32'h0);
    rd(4'h2, v);
    check("R2 enable unaffected by stray writes", v, 32'h00F0_0000);
    rd(4'h0, v);
    check("R2 pending unaffected by stray writes", v, 32'h0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_rising_latency();
    t_falling();
    t_level_high();
    t_level_low_crit();
    t_race();
    t_ignored();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule